// File: doc/BRIEF.md
# Coarse-Fine Pulse Timestamp Encoder

This block timestamps both edges of one discriminator pulse for a time-to-digital converter channel. A tapped delay line outside the block is sampled each system clock (250 MHz, 4 ns per coarse step). Its thermometer snapshot arrives on `therm_i`. The block filters single-tap bubbles and locates the transition inside the snapshot, which gives a 6-bit fine code spanning exactly one clock period. It joins that code with a free-running 16-bit coarse counter to form a 22-bit edge timestamp.

A rising transition starts a pulse and a falling transition ends it. The block pairs each leading edge with the trailing edge that follows. It reports the leading timestamp and the time-over-threshold width as one record on a valid/ready output. A two-entry output stage (head register plus one skid slot) absorbs back-pressure. Unpaired edges, timed-out pulses and dropped records are flagged, so a downstream merger can account for them.

Top module: `tdc_hit_enc`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `rec_valid_o` is 0 and `err_cnt_o` is 0.
- R2: Each tap is replaced by the majority of itself and its two neighbours (the end taps keep their value) before decoding. A single-tap bubble therefore leaves the fine code unchanged. Tap 0 is the latest-entering tap, and the fine code is the index of the first filtered tap that differs from tap 0.
- R3: A leading edge is a snapshot whose filtered tap 0 is 1 and which has a transition, following an all-zeros snapshot. Its timestamp is `{C, 6'b0} - fine` modulo 2^22. C is the coarse count sampled in the clock edge that captures the snapshot: 0 at the first edge after reset, plus 1 per edge.
- R4: A trailing edge is a snapshot with filtered tap 0 equal to 0 and a transition, following an all-ones snapshot, with its timestamp formed as in R3. When a leading edge is pending, the block emits a record with that leading timestamp, `width = trailing - leading` modulo 2^22 (low 15 bits), timeout flag 0 and lost flag 0.
- R5: A snapshot sequence zero→ones, ones→zero, zero→falling-partial or partial→partial produces no edge, no record and no error count.
- R6: A trailing edge with no pending leading edge is discarded and increments `err_cnt_o`, which saturates at 255.
- R7: A leading edge that arrives while another is pending replaces it, and `err_cnt_o` increments.
- R8: A trailing edge whose coarse count is at most 256 above the leading one is paired. Otherwise the leading edge is flushed 256 coarse cycles after it as a record with timeout flag 1 and width 0, and the late trailing edge is then handled as in R6.
- R9: The coarse counter wraps at 2^16, and a pulse that spans the wrap gets its correct width.
- R10: While `rec_ready_i` is low, `rec_valid_o` and the record stay unchanged. Two records are held. A record that completes while both are full is discarded, and the next stored record carries lost flag 1; later records carry 0. Records leave in completion order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| therm_i | input | 64 | Registered delay-line thermometer snapshot |
| rec_ready_i | input | 1 | Downstream accepts the record |
| rec_valid_o | output | 1 | Record available |
| rec_lead_ts_o | output | 22 | Leading-edge timestamp {coarse, fine} |
| rec_width_o | output | 15 | Time-over-threshold in fine units |
| rec_tout_o | output | 1 | Pulse flushed without a trailing edge |
| rec_lost_o | output | 1 | At least one earlier record was dropped |
| err_cnt_o | output | 8 | Saturating count of unpaired edges |

## Verification
The hardest condition to reach is a record completing while both output slots are full. The stimulus holds `rec_ready_i` low across three complete pulses, then releases it and sends one more pulse to see where the lost flag lands. The coarse wrap is the other hard case. The stimulus idles until the counter sits just below 2^16 and then launches a pulse that straddles the wrap. The 256-cycle pairing limit is approached from both sides, one pulse exactly at the limit and one a cycle past it.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_ONE  = 2'd1,
    CLS_RISE = 2'd2,
    CLS_FALL = 2'd3
  } snap_cls_e;
endpackage

// File: rtl/tdc_fine_enc.sv
module tdc_fine_enc
  import tdc_pkg::*;
#(
  parameter int TAPS   = 64,
  parameter int FINE_W = $clog2(TAPS)
) (
  input  logic [TAPS-1:0]   snap_i,
  output snap_cls_e         cls_o,
  output logic [FINE_W-1:0] fine_o
);
  logic [TAPS-1:0] filt;

  // 3-tap majority bubble filter; end taps pass through
  for (genvar g = 0; g < TAPS; g++) begin : g_filt
    if (g == 0 || g == TAPS-1) begin : g_end
      assign filt[g] = snap_i[g];
    end else begin : g_mid
      assign filt[g] = (snap_i[g-1] & snap_i[g]) | (snap_i[g] & snap_i[g+1]) |
                       (snap_i[g-1] & snap_i[g+1]);
    end
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    fine_o = '0;
    for (int i = 1; i < TAPS; i++) begin
      if (!found && (filt[i] != filt[0])) begin
        fine_o = FINE_W'(i);
        found  = 1'b1;
      end
    end
    if (!found) cls_o = filt[0] ? CLS_ONE : CLS_ZERO;
    else        cls_o = filt[0] ? CLS_RISE : CLS_FALL;
  end
endmodule

// File: rtl/tdc_edge_det.sv
module tdc_edge_det
  import tdc_pkg::*;
#(
  parameter int TAPS     = 64,
  parameter int COARSE_W = 16,
  parameter int FINE_W   = $clog2(TAPS),
  parameter int TS_W     = COARSE_W + FINE_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TAPS-1:0] therm_i,
  output logic            evt_vld_o,
  output logic            evt_lead_o,
  output logic [TS_W-1:0] evt_ts_o
);
  logic [COARSE_W-1:0] coarse_q, stamp_q;
  logic [TAPS-1:0]     snap_q;
  snap_cls_e           cls, prev_cls_q;
  logic [FINE_W-1:0]   fine;
  logic                hit_rise, hit_fall;
  logic [TS_W-1:0]     ts;

  tdc_fine_enc #(.TAPS(TAPS), .FINE_W(FINE_W)) u_enc (
    .snap_i (snap_q),
    .cls_o  (cls),
    .fine_o (fine)
  );

  assign hit_rise = (prev_cls_q == CLS_ZERO) && (cls == CLS_RISE);
  assign hit_fall = (prev_cls_q == CLS_ONE)  && (cls == CLS_FALL);
  // fine counts back from the capturing edge
  assign ts = {stamp_q, {FINE_W{1'b0}}} - {{COARSE_W{1'b0}}, fine};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coarse_q   <= '0;
      stamp_q    <= '0;
      snap_q     <= '0;
      prev_cls_q <= CLS_ZERO;
      evt_vld_o  <= 1'b0;
      evt_lead_o <= 1'b0;
      evt_ts_o   <= '0;
    end else begin
      coarse_q   <= coarse_q + 1'b1;
      stamp_q    <= coarse_q;
      snap_q     <= therm_i;
      prev_cls_q <= cls;
      evt_vld_o  <= hit_rise | hit_fall;
      evt_lead_o <= hit_rise;
      evt_ts_o   <= ts;
    end
  end
endmodule

// File: rtl/tdc_pair.sv
module tdc_pair #(
  parameter int TS_W     = 22,
  parameter int WID_W    = 15,
  parameter int TOUT_CYC = 256,
  parameter int ERR_W    = 8,
  parameter int AGE_W    = $clog2(TOUT_CYC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_vld_i,
  input  logic             evt_lead_i,
  input  logic [TS_W-1:0]  evt_ts_i,
  output logic             rec_vld_o,
  output logic [TS_W-1:0]  rec_lead_ts_o,
  output logic [WID_W-1:0] rec_width_o,
  output logic             rec_tout_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  logic             pend_q;
  logic [TS_W-1:0]  lead_q, diff;
  logic [AGE_W-1:0] age_q;
  logic             lead_in, trail_hit, orphan, tout_hit, replace;

  assign lead_in   = evt_vld_i & evt_lead_i;
  assign trail_hit = evt_vld_i & ~evt_lead_i & pend_q;
  assign orphan    = evt_vld_i & ~evt_lead_i & ~pend_q;
  assign tout_hit  = pend_q & ~trail_hit & (age_q == AGE_W'(TOUT_CYC-1));
  // a lead during a flush cycle is not an error: the old one leaves as timeout
  assign replace   = lead_in & pend_q & ~tout_hit;

  assign diff          = evt_ts_i - lead_q;
  assign rec_vld_o     = trail_hit | tout_hit;
  assign rec_lead_ts_o = lead_q;
  assign rec_width_o   = trail_hit ? diff[WID_W-1:0] : '0;
  assign rec_tout_o    = tout_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      lead_q    <= '0;
      age_q     <= '0;
      err_cnt_o <= '0;
    end else begin
      if (lead_in) begin
        pend_q <= 1'b1;
        lead_q <= evt_ts_i;
        age_q  <= '0;
      end else if (trail_hit || tout_hit) begin
        pend_q <= 1'b0;
      end else if (pend_q) begin
        age_q <= age_q + 1'b1;
      end
      if ((orphan || replace) && (err_cnt_o != {ERR_W{1'b1}}))
        err_cnt_o <= err_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/tdc_skid.sv
module tdc_skid #(
  parameter int W = 38
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W:0]   data_o
);
  logic [W:0] head_q, skid_q, entry;
  logic       head_v_q, skid_v_q, lost_q;
  logic       pop, full, drop, store;

  assign pop   = head_v_q & ready_i;
  assign full  = head_v_q & skid_v_q;
  assign drop  = push_i & full & ~pop;
  assign store = push_i & ~drop;
  assign entry = {lost_q, data_i};

  assign valid_o = head_v_q;
  assign data_o  = head_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q   <= '0;
      skid_q   <= '0;
      head_v_q <= 1'b0;
      skid_v_q <= 1'b0;
      lost_q   <= 1'b0;
    end else begin
      if (drop)       lost_q <= 1'b1;
      else if (store) lost_q <= 1'b0;

      if (pop) begin
        if (skid_v_q) begin
          head_q <= skid_q;
          if (store) skid_q   <= entry;
          else       skid_v_q <= 1'b0;
        end else if (store) begin
          head_q <= entry;
        end else begin
          head_v_q <= 1'b0;
        end
      end else if (store) begin
        if (!head_v_q) begin
          head_q   <= entry;
          head_v_q <= 1'b1;
        end else begin
          skid_q   <= entry;
          skid_v_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tdc_hit_enc.sv
module tdc_hit_enc #(
  parameter  int TAPS     = 64,
  parameter  int COARSE_W = 16,
  parameter  int TOUT_CYC = 256,
  parameter  int ERR_W    = 8,
  localparam int FINE_W   = $clog2(TAPS),
  localparam int TS_W     = COARSE_W + FINE_W,
  localparam int WID_W    = $clog2(TOUT_CYC + 1) + FINE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAPS-1:0]  therm_i,
  input  logic             rec_ready_i,
  output logic             rec_valid_o,
  output logic [TS_W-1:0]  rec_lead_ts_o,
  output logic [WID_W-1:0] rec_width_o,
  output logic             rec_tout_o,
  output logic             rec_lost_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  localparam int REC_W = TS_W + WID_W + 1;

  logic             evt_vld, evt_lead;
  logic [TS_W-1:0]  evt_ts, pr_ts;
  logic             pr_vld, pr_tout;
  logic [WID_W-1:0] pr_width;
  logic [REC_W:0]   out_rec;

  tdc_edge_det #(
    .TAPS(TAPS), .COARSE_W(COARSE_W), .FINE_W(FINE_W), .TS_W(TS_W)
  ) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .therm_i    (therm_i),
    .evt_vld_o  (evt_vld),
    .evt_lead_o (evt_lead),
    .evt_ts_o   (evt_ts)
  );

  tdc_pair #(
    .TS_W(TS_W), .WID_W(WID_W), .TOUT_CYC(TOUT_CYC), .ERR_W(ERR_W)
  ) u_pair (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .evt_vld_i     (evt_vld),
    .evt_lead_i    (evt_lead),
    .evt_ts_i      (evt_ts),
    .rec_vld_o     (pr_vld),
    .rec_lead_ts_o (pr_ts),
    .rec_width_o   (pr_width),
    .rec_tout_o    (pr_tout),
    .err_cnt_o     (err_cnt_o)
  );

  tdc_skid #(.W(REC_W)) u_skid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (pr_vld),
    .data_i  ({pr_ts, pr_width, pr_tout}),
    .ready_i (rec_ready_i),
    .valid_o (rec_valid_o),
    .data_o  (out_rec)
  );

  assign {rec_lost_o, rec_lead_ts_o, rec_width_o, rec_tout_o} = out_rec;
endmodule

// File: rtl/tdc_hit_enc_chk.sv
module tdc_hit_enc_chk #(
  parameter int TS_W  = 22,
  parameter int WID_W = 15,
  parameter int ERR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rec_ready_i,
  input logic             rec_valid_o,
  input logic [TS_W-1:0]  rec_lead_ts_o,
  input logic [WID_W-1:0] rec_width_o,
  input logic             rec_tout_o,
  input logic             rec_lost_o,
  input logic [ERR_W-1:0] err_cnt_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (!rec_valid_o && err_cnt_o == '0);
    end
  end

  a_r10_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_lead_ts_o) &&
      $stable(rec_width_o) && $stable(rec_tout_o) && $stable(rec_lost_o));

  a_r6_err_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (err_cnt_o == $past(err_cnt_o)) ||
             (err_cnt_o == $past(err_cnt_o) + 1'b1));

  a_r8_tout_zero_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_tout_o |-> rec_width_o == '0);

  a_r4_pair_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_tout_o |-> rec_width_o != '0);
endmodule

bind tdc_hit_enc tdc_hit_enc_chk #(
  .TS_W(TS_W), .WID_W(WID_W), .ERR_W(ERR_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rec_ready_i   (rec_ready_i),
  .rec_valid_o   (rec_valid_o),
  .rec_lead_ts_o (rec_lead_ts_o),
  .rec_width_o   (rec_width_o),
  .rec_tout_o    (rec_tout_o),
  .rec_lost_o    (rec_lost_o),
  .err_cnt_o     (err_cnt_o)
);

// File: tb/sim_tdc_hit_enc.sv
module sim_tdc_hit_enc;
  localparam int CLK_P = 10;
  localparam logic [63:0] ONES = '1;
  // {lead fine, coarse gap, trail fine}
  localparam int VEC [8][3] = '{
    '{1, 2, 63}, '{63, 2, 1}, '{20, 5, 20}, '{32, 17, 7},
    '{5, 100, 60}, '{40, 256, 3}, '{10, 3, 10}, '{50, 40, 50}};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] therm_i = '0;
  logic        rec_ready_i = 1'b1;
  logic        rec_valid_o, rec_tout_o, rec_lost_o;
  logic [21:0] rec_lead_ts_o;
  logic [14:0] rec_width_o;
  logic [7:0]  err_cnt_o;

  logic [15:0] bc;
  logic [21:0] g_ts [64];
  logic [14:0] g_w  [64];
  logic        g_to [64];
  logic        g_lo [64];
  int n_got = 0, n_chk = 0, n_bad = 0, exp_err = 0;
  bit done = 0;

  tdc_hit_enc u0 (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) bc <= '0; else bc <= bc + 1'b1;

  always @(negedge clk_i) begin
    #1;
    if (rst_ni && rec_valid_o && rec_ready_i && n_got < 64) begin
      g_ts[n_got] = rec_lead_ts_o;
      g_w[n_got]  = rec_width_o;
      g_to[n_got] = rec_tout_o;
      g_lo[n_got] = rec_lost_o;
      n_got++;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [63:0] rise(int f);
    return (64'd1 << f) - 64'd1;
  endfunction

  function automatic logic [63:0] fall(int f);
    return ~rise(f);
  endfunction

  task automatic drive(logic [63:0] w, output logic [15:0] st);
    @(negedge clk_i);
    therm_i = w;
    st = bc;
  endtask

  task automatic idle(int n);
    logic [15:0] d;
    for (int i = 0; i < n; i++) drive('0, d);
  endtask

  task automatic pulse(int fl, int gap, int ft, logic [63:0] rw, logic [63:0] fw,
                       output logic [21:0] ets, output logic [14:0] ew);
    logic [15:0] cl, ct, d;
    logic [21:0] tr;
    drive('0, d);
    drive(rw, cl);
    for (int i = 1; i < gap; i++) drive(ONES, d);
    drive(fw, ct);
    drive('0, d);
    ets = {cl, 6'b0} - 22'(fl);
    tr  = {ct, 6'b0} - 22'(ft);
    ew  = 15'(tr - ets);
  endtask

  task automatic wait_got(int n, string req);
    int t = 0;
    while (n_got < n && t < 40) begin
      @(negedge clk_i); #2; t++;
    end
    check({req, " record count"}, n_got, n);
  endtask

  task automatic check_rec(int i, string req, logic [21:0] ts, logic [14:0] w,
                           logic to, logic lo);
    check({req, " lead_ts"}, g_ts[i], ts);
    check({req, " width"}, g_w[i], w);
    check({req, " tout"}, g_to[i], to);
    check({req, " lost"}, g_lo[i], lo);
  endtask

  initial begin
    #(CLK_P * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [21:0] ts, ts_a, ts_b, ts_d;
    logic [14:0] w, w_a, w_b, w_d;
    logic [15:0] d, cl;
    int base;

    // R1
    repeat (3) @(negedge clk_i);
    check("R1 valid in reset", rec_valid_o, 0);
    check("R1 err in reset", err_cnt_o, 0);
    rst_ni = 1'b1;
    idle(3);
    check("R1 valid after reset", rec_valid_o, 0);

    // R3 R4 R8 table walk
    for (int k = 0; k < 8; k++) begin
      base = n_got;
      pulse(VEC[k][0], VEC[k][1], VEC[k][2], rise(VEC[k][0]), fall(VEC[k][2]), ts, w);
      wait_got(base + 1, "R4");
      check_rec(base, (VEC[k][1] == 256) ? "R8 limit pair" : "R3 R4 pair", ts, w, 0, 0);
    end
    check("R4 no err", err_cnt_o, exp_err);

    // R2 bubbles in both edge snapshots and in the all-ones stretch
    base = n_got;
    pulse(20, 3, 12, rise(20) & ~(64'd1 << 7) | (64'd1 << 40),
          fall(12) | (64'd1 << 5), ts, w);
    wait_got(base + 1, "R2");
    check_rec(base, "R2 bubble", ts, w, 0, 0);

    // R5 boundary edges and a falling partial after zeros
    base = n_got;
    drive('0, d); drive(ONES, d); drive(ONES, d); drive('0, d);
    drive(fall(10), d); drive('0, d);
    idle(6);
    check("R5 no record", n_got, base);
    check("R5 no err", err_cnt_o, exp_err);
    // partial after partial: only the first rise counts
    drive('0, d); drive(rise(10), cl); drive(rise(20), d); drive(ONES, d);
    drive(fall(5), d); drive('0, d);
    wait_got(base + 1, "R5");
    check_rec(base, "R5 single lead", {cl, 6'b0} - 22'd10, 15'(3 * 64 - 5 + 10), 0, 0);
    check("R5 err after double rise", err_cnt_o, exp_err);

    // R7 second lead replaces the first
    base = n_got;
    drive('0, d); drive(rise(10), d); drive(ONES, d); drive('0, d);
    drive(rise(30), cl); drive(ONES, d); drive(ONES, d); drive(fall(5), d);
    drive('0, d);
    exp_err++;
    wait_got(base + 1, "R7");
    check_rec(base, "R7 replace", {cl, 6'b0} - 22'd30, 15'(3 * 64 - 5 + 30), 0, 0);
    check("R7 err", err_cnt_o, exp_err);

    // R8 one coarse cycle past the limit
    base = n_got;
    drive('0, d); drive(rise(17), cl);
    for (int i = 1; i < 257; i++) drive(ONES, d);
    drive(fall(4), d); drive('0, d);
    exp_err++;
    wait_got(base + 1, "R8");
    idle(4);
    check_rec(base, "R8 timeout", {cl, 6'b0} - 22'd17, 0, 1, 0);
    check("R8 late trail err", err_cnt_o, exp_err);
    check("R8 single record", n_got, base + 1);

    // R10 back-pressure and overflow
    base = n_got;
    @(negedge clk_i); rec_ready_i = 1'b0;
    pulse(11, 3, 22, rise(11), fall(22), ts_a, w_a);
    pulse(33, 4, 44, rise(33), fall(44), ts_b, w_b);
    pulse(55, 5, 6, rise(55), fall(6), ts, w);
    idle(5);
    check("R10 valid held", rec_valid_o, 1);
    check("R10 head stable", rec_lead_ts_o, ts_a);
    check("R10 nothing taken", n_got, base);
    @(negedge clk_i); rec_ready_i = 1'b1;
    wait_got(base + 2, "R10");
    idle(4);
    check("R10 third dropped", n_got, base + 2);
    check_rec(base, "R10 first", ts_a, w_a, 0, 0);
    check_rec(base + 1, "R10 second", ts_b, w_b, 0, 0);
    pulse(9, 2, 9, rise(9), fall(9), ts_d, w_d);
    wait_got(base + 3, "R10");
    check_rec(base + 2, "R10 lost marked", ts_d, w_d, 0, 1);
    pulse(8, 6, 2, rise(8), fall(2), ts, w);
    wait_got(base + 4, "R10");
    check_rec(base + 3, "R10 lost cleared", ts, w, 0, 0);

    // R9 pulse spanning the coarse wrap
    while (bc != 16'hFFFD) @(negedge clk_i);
    base = n_got;
    pulse(40, 4, 9, rise(40), fall(9), ts, w);
    wait_got(base + 1, "R9");
    check_rec(base, "R9 wrap", ts, w, 0, 0);
    check("R9 width value", w, 15'(4 * 64 - 9 + 40));

    // R6 orphan trailing edges and saturation
    drive(ONES, d); drive(fall(5), d); drive('0, d);
    exp_err++;
    idle(4);
    check("R6 orphan counted", err_cnt_o, exp_err);
    for (int i = 0; i < 260; i++) begin
      drive(ONES, d); drive(fall(5), d);
    end
    idle(5);
    check("R6 saturate", err_cnt_o, 255);
    check("R6 no record", n_got, base + 1);

    finish_run();
  end
endmodule